// File: doc/BRIEF.md
# Memory Image Checksum Engine

This block produces a 16-bit verification checksum for a memory image that is streamed into it one word per clock. A host pulses `start`, then presents 14-bit program words with their addresses on a valid-qualified stream and flags the final beat with `wlast`. The configuration word and the four identification words are presented on their own inputs and are sampled on the beat that carries `wlast`.

The code-protection setting comes from the configuration word and selects between two formulas. Without protection, the checksum is the sum of the low program words plus a masked copy of the configuration word. With protection, the program words do not count. The checksum is then the masked configuration word plus a 16-bit value built from one nibble of each ID word. All arithmetic wraps at 16 bits.

The result appears one cycle after the last beat, with a single-cycle `done` pulse. It then stays on `checksum` until the next image completes.

Top module: `checksum_engine`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `checksum` reads 0x0000 and `done` reads 0.
- R2: A `start` pulse clears the running sum. A stream beat presented in the same cycle as `start` is ignored, including its `wlast`.
- R3: Each accepted beat (`wvalid` high, `start` low) whose address is below 0x3FF adds its 14-bit word to the running sum. The running sum is kept modulo 2^16.
- R4: A beat whose address is 0x3FF or above leaves the running sum unchanged.
- R5: Protection is read from bit 7 of `cfg_word`. When that bit is 1 (protection off), the result is the running sum plus (`cfg_word` AND 0x01FF), modulo 2^16.
- R6: When bit 7 of `cfg_word` is 0 (protection on), the result is (`cfg_word` AND 0x01FF) plus a packed ID value, modulo 2^16. ID word k sits at `id_words[14k+13:14k]`. Bits [3:0] of ID word 0 form result bits [15:12], ID word 1 forms [11:8], ID word 2 forms [7:4] and ID word 3 forms [3:0]. Program words have no effect in this mode.
- R7: `done` goes high for exactly one cycle, one cycle after an accepted beat with `wlast`. `cfg_word` and `id_words` are sampled on that beat. `checksum` holds its value until the next such completion.
- R8: A blank unprotected image gives 0xBE00. A blank image has every address from 0x000 to 0x3FE holding 0x3FFF, with `cfg_word` = 0x3FFF.
- R9: The word carried by the `wlast` beat is itself included in the sum when its address is in range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new image; clears the running sum |
| wvalid | input | 1 | Stream beat valid |
| waddr | input | 14 | Word address of the beat |
| wdata | input | 14 | Program word of the beat |
| wlast | input | 1 | Marks the final beat of the image |
| cfg_word | input | 14 | Configuration word; bit 7 selects protection |
| id_words | input | 56 | Four ID words, ID word k at bits [14k+13:14k] |
| checksum | output | 16 | Checksum of the last completed image |
| done | output | 1 | One-cycle pulse when `checksum` is updated |

## Verification
The properties assume three things about the inputs. `cfg_word` and `id_words` are valid on the beat that carries `wlast`. `wlast` is only meaningful together with `wvalid`. All inputs are held low while reset is applied. The bench changes inputs only on falling edges and raises `wlast` only on a valid beat. It sweeps addresses across the range limit, sweeps the protection mode, the configuration bits and the ID nibbles, and puts a stream beat in the same cycle as a `start` pulse. Every expected sum is formed by plain integer arithmetic, separately from the design.

// File: rtl/csum_pkg.sv
package csum_pkg;

    localparam int WORD_W     = 14;
    localparam int ADDR_W     = 14;
    localparam int SUM_W      = 16;
    localparam int ID_CNT     = 4;
    localparam int NIB_W      = 4;
    localparam int CP_POS     = 7;
    localparam int ADDR_LIMIT = 'h3FF;
    localparam int CFG_KEEP   = 'h01FF;

    typedef enum logic {
        PROT_OFF = 1'b0,
        PROT_ON  = 1'b1
    } prot_e;

    typedef struct packed {
        logic take;
        logic accept;
    } gate_t;

    function automatic prot_e prot_from_bit(input logic cp_bit);
        return cp_bit ? PROT_OFF : PROT_ON;
    endfunction

endpackage

// File: rtl/csum_gate.sv
module csum_gate #(
    parameter int ADDR_W     = csum_pkg::ADDR_W,
    parameter int ADDR_LIMIT = csum_pkg::ADDR_LIMIT
) (
    input  logic              start,
    input  logic              wvalid,
    input  logic              wlast,
    input  logic [ADDR_W-1:0] waddr,
    output csum_pkg::gate_t   gate
);
    localparam logic [ADDR_W-1:0] LIMIT_V = ADDR_W'(ADDR_LIMIT);

    logic beat_ok;
    logic in_range;

    always_comb begin
        beat_ok     = wvalid && !start;
        in_range    = (waddr < LIMIT_V);
        gate.take   = beat_ok && in_range;
        gate.accept = beat_ok && wlast;
    end
endmodule

// File: rtl/csum_accum.sv
module csum_accum #(
    parameter int WORD_W = csum_pkg::WORD_W,
    parameter int SUM_W  = csum_pkg::SUM_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              take,
    input  logic [WORD_W-1:0] data,
    output logic [SUM_W-1:0]  acc_q,
    output logic [SUM_W-1:0]  acc_next
);
    always_comb begin
        if (clr)
            acc_next = '0;
        else if (take)
            acc_next = acc_q + SUM_W'(data);
        else
            acc_next = acc_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else
            acc_q <= acc_next;
    end
endmodule

// File: rtl/csum_final.sv
module csum_final #(
    parameter int WORD_W   = csum_pkg::WORD_W,
    parameter int SUM_W    = csum_pkg::SUM_W,
    parameter int ID_CNT   = csum_pkg::ID_CNT,
    parameter int NIB_W    = csum_pkg::NIB_W,
    parameter int CP_POS   = csum_pkg::CP_POS,
    parameter int CFG_KEEP = csum_pkg::CFG_KEEP
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     accept,
    input  logic [SUM_W-1:0]         acc_next,
    input  logic [WORD_W-1:0]        cfg_word,
    input  logic [ID_CNT*WORD_W-1:0] id_words,
    output logic [SUM_W-1:0]         checksum,
    output logic                     done
);
    import csum_pkg::*;

    localparam logic [SUM_W-1:0] KEEP_V = SUM_W'(CFG_KEEP);

    logic [SUM_W-1:0] id_pack;
    logic [SUM_W-1:0] cfg_term;
    logic [SUM_W-1:0] result;
    prot_e            mode;

    for (genvar k = 0; k < ID_CNT; k++) begin : g_pack
        assign id_pack[SUM_W-1-k*NIB_W -: NIB_W] = id_words[k*WORD_W +: NIB_W];
    end

    always_comb begin
        cfg_term = SUM_W'(cfg_word) & KEEP_V;
        mode     = prot_from_bit(cfg_word[CP_POS]);
        case (mode)
            PROT_ON: result = cfg_term + id_pack;
            default: result = acc_next + cfg_term;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            checksum <= '0;
            done     <= 1'b0;
        end else begin
            done <= accept;
            if (accept)
                checksum <= result;
        end
    end
endmodule

// File: rtl/checksum_engine.sv
module checksum_engine #(
    parameter int WORD_W     = csum_pkg::WORD_W,
    parameter int ADDR_W     = csum_pkg::ADDR_W,
    parameter int SUM_W      = csum_pkg::SUM_W,
    parameter int ID_CNT     = csum_pkg::ID_CNT,
    parameter int NIB_W      = csum_pkg::NIB_W,
    parameter int CP_POS     = csum_pkg::CP_POS,
    parameter int ADDR_LIMIT = csum_pkg::ADDR_LIMIT,
    parameter int CFG_KEEP   = csum_pkg::CFG_KEEP
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic                     wvalid,
    input  logic [ADDR_W-1:0]        waddr,
    input  logic [WORD_W-1:0]        wdata,
    input  logic                     wlast,
    input  logic [WORD_W-1:0]        cfg_word,
    input  logic [ID_CNT*WORD_W-1:0] id_words,
    output logic [SUM_W-1:0]         checksum,
    output logic                     done
);
    csum_pkg::gate_t  gate;
    logic [SUM_W-1:0] acc_q;
    logic [SUM_W-1:0] acc_next;

    csum_gate #(
        .ADDR_W     (ADDR_W),
        .ADDR_LIMIT (ADDR_LIMIT)
    ) u_gate (
        .start  (start),
        .wvalid (wvalid),
        .wlast  (wlast),
        .waddr  (waddr),
        .gate   (gate)
    );

    csum_accum #(
        .WORD_W (WORD_W),
        .SUM_W  (SUM_W)
    ) u_accum (
        .clk      (clk),
        .rst      (rst),
        .clr      (start),
        .take     (gate.take),
        .data     (wdata),
        .acc_q    (acc_q),
        .acc_next (acc_next)
    );

    csum_final #(
        .WORD_W   (WORD_W),
        .SUM_W    (SUM_W),
        .ID_CNT   (ID_CNT),
        .NIB_W    (NIB_W),
        .CP_POS   (CP_POS),
        .CFG_KEEP (CFG_KEEP)
    ) u_final (
        .clk      (clk),
        .rst      (rst),
        .accept   (gate.accept),
        .acc_next (acc_next),
        .cfg_word (cfg_word),
        .id_words (id_words),
        .checksum (checksum),
        .done     (done)
    );
endmodule

// File: rtl/csum_checker.sv
module csum_checker #(
    parameter int WORD_W     = csum_pkg::WORD_W,
    parameter int ADDR_W     = csum_pkg::ADDR_W,
    parameter int SUM_W      = csum_pkg::SUM_W,
    parameter int ID_CNT     = csum_pkg::ID_CNT,
    parameter int NIB_W      = csum_pkg::NIB_W,
    parameter int CP_POS     = csum_pkg::CP_POS,
    parameter int ADDR_LIMIT = csum_pkg::ADDR_LIMIT,
    parameter int CFG_KEEP   = csum_pkg::CFG_KEEP
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     start,
    input logic                     wvalid,
    input logic [ADDR_W-1:0]        waddr,
    input logic [WORD_W-1:0]        wdata,
    input logic                     wlast,
    input logic [WORD_W-1:0]        cfg_word,
    input logic [ID_CNT*WORD_W-1:0] id_words,
    input logic [SUM_W-1:0]         checksum,
    input logic                     done,
    input logic [SUM_W-1:0]         acc_q
);
    localparam logic [ADDR_W-1:0] LIMIT_V = ADDR_W'(ADDR_LIMIT);

    // Expected protected result, formed from inputs seen on the last beat.
    logic [SUM_W-1:0] prot_expect;
    logic [SUM_W-1:0] prot_expect_q;
    logic             prot_sel_q;

    always_comb begin
        logic [SUM_W-1:0] ids_v;
        ids_v = '0;
        for (int k = 0; k < ID_CNT; k++)
            ids_v = (ids_v << NIB_W) | SUM_W'(id_words[k*WORD_W +: NIB_W]);
        prot_expect = ids_v + (SUM_W'(cfg_word) & SUM_W'(CFG_KEEP));
    end

    always_ff @(posedge clk) begin
        prot_expect_q <= prot_expect;
        prot_sel_q    <= !cfg_word[CP_POS];
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!done && checksum == '0));

    a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
        start |=> acc_q == '0);

    a_r3_low_adds: assert property (@(posedge clk) disable iff (rst)
        (wvalid && !start && waddr < LIMIT_V)
        |=> acc_q == SUM_W'($past(acc_q) + SUM_W'($past(wdata))));

    a_r4_high_ignored: assert property (@(posedge clk) disable iff (rst)
        (wvalid && !start && waddr >= LIMIT_V) |=> acc_q == $past(acc_q));

    a_r7_done_cause: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(wvalid && wlast && !start));

    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (!done && !$past(rst)) |-> $stable(checksum));

    a_r6_protected: assert property (@(posedge clk) disable iff (rst)
        (done && prot_sel_q) |-> checksum == prot_expect_q);
endmodule

bind checksum_engine csum_checker #(
    .WORD_W     (WORD_W),
    .ADDR_W     (ADDR_W),
    .SUM_W      (SUM_W),
    .ID_CNT     (ID_CNT),
    .NIB_W      (NIB_W),
    .CP_POS     (CP_POS),
    .ADDR_LIMIT (ADDR_LIMIT),
    .CFG_KEEP   (CFG_KEEP)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .wvalid   (wvalid),
    .waddr    (waddr),
    .wdata    (wdata),
    .wlast    (wlast),
    .cfg_word (cfg_word),
    .id_words (id_words),
    .checksum (checksum),
    .done     (done),
    .acc_q    (acc_q)
);

// File: tb/checksum_engine_test.sv
module checksum_engine_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        wvalid = 1'b0;
    logic [13:0] waddr = '0;
    logic [13:0] wdata = '0;
    logic        wlast = 1'b0;
    logic [13:0] cfg_word = '0;
    logic [55:0] id_words = '0;
    logic [15:0] checksum;
    logic        done;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    checksum_engine uut (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .wvalid   (wvalid),
        .waddr    (waddr),
        .wdata    (wdata),
        .wlast    (wlast),
        .cfg_word (cfg_word),
        .id_words (id_words),
        .checksum (checksum),
        .done     (done)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [13:0] pat(input int a, input int s);
        return 14'((a * 37) + (s * 101) + (a >> 3) + 5);
    endfunction

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1; wvalid = 1'b0; wlast = 1'b0;
    endtask

    task automatic send(input int a, input logic [13:0] d, input logic l);
        @(negedge clk);
        start = 1'b0; wvalid = 1'b1; waddr = 14'(a); wdata = d; wlast = l;
    endtask

    // Sample the cycle after the last beat, then once more for the pulse end.
    task automatic finish(input string tag, input logic [15:0] exp);
        @(negedge clk);
        check({tag, " R7 done high"}, done, 1'b1);
        check({tag, " value"}, checksum, exp);
        wvalid = 1'b0; wlast = 1'b0;
        @(negedge clk);
        check({tag, " R7 done single"}, done, 1'b0);
        check({tag, " R7 hold"}, checksum, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] e;
        repeat (3) @(negedge clk);
        check("R1 reset checksum", checksum, 16'h0);
        check("R1 reset done", done, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset checksum", checksum, 16'h0);

        // R8 blank image, R5 with CP=1
        cfg_word = 14'h3FFF;
        pulse_start();
        for (int a = 0; a < 'h3FF; a++) send(a, 14'h3FFF, a == 'h3FE);
        finish("R8 blank", 16'hBE00);

        // R3 R4 R9 address sweep across the limit
        cfg_word = 14'h2A95;
        e = 16'(14'h2A95 & 14'h01FF);
        pulse_start();
        for (int a = 0; a < 'h500; a++) begin
            if (a < 'h3FF) e = e + 16'(pat(a, 1));
            send(a, pat(a, 1), a == 'h4FF);
        end
        finish("R3 R4 sweep", e);

        // R9 last word counted, R4 only high addresses present
        pulse_start();
        send('h10, 14'h0123, 1'b0);
        send('h3FE, 14'h0456, 1'b1);
        finish("R9 last word", 16'(14'h0123 + 14'h0456 + 14'h0095));
        pulse_start();
        for (int a = 'h3FF; a < 'h410; a++) send(a, 14'h3FFF, a == 'h40F);
        finish("R4 high only", 16'h0095);

        // R5 configuration sweep, protection off
        for (int v = 0; v < 8; v++) begin
            cfg_word = 14'((v * 'h1357) | 'h80);
            e = 16'(cfg_word & 14'h01FF) + 16'(pat(v, 2)) + 16'(pat(v + 1, 2));
            pulse_start();
            send(v, pat(v, 2), 1'b0);
            send(v + 1, pat(v + 1, 2), 1'b1);
            finish("R5 cfg sweep", e);
        end

        // R6 protected, nibble sweep with junk upper ID bits
        for (int v = 0; v < 16; v++) begin
            cfg_word = 14'((v * 'h0B3D) & ~'h80);
            for (int k = 0; k < 4; k++)
                id_words[k*14 +: 14] = {10'(v * 7 + k * 3 + 1), 4'((v + k * 5) & 15)};
            e = 16'(cfg_word & 14'h01FF)
              + {4'((v) & 15), 4'((v + 5) & 15), 4'((v + 10) & 15), 4'((v + 15) & 15)};
            pulse_start();
            for (int a = 0; a < 6; a++) send(a, pat(a, v), a == 5);
            finish("R6 protected", e);
        end

        // R2 start clears, beat in start cycle ignored
        cfg_word = 14'h0080;
        pulse_start();
        for (int a = 0; a < 10; a++) send(a, pat(a, 3), 1'b0);
        @(negedge clk);
        start = 1'b1; wvalid = 1'b1; waddr = 14'd10; wdata = 14'h1234; wlast = 1'b1;
        e = 16'h0080;
        for (int a = 11; a < 21; a++) begin
            e = e + 16'(pat(a, 3));
            send(a, pat(a, 3), a == 20);
        end
        check("R2 no done for start-cycle last", done, 1'b0);
        finish("R2 start clears", e);

        // R1 mid-run reset
        repeat (3) @(negedge clk);
        check("R7 idle hold", checksum, e);
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid reset checksum", checksum, 16'h0);
        check("R1 mid reset done", done, 1'b0);
        rst = 1'b0;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule